// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Software arms it through a start bit. The conversion then begins either at once or on a hardware capture request from a timer. The block picks one of twelve analog inputs through a multiplexer select. It runs a binary search on a 10-bit trial code driven to the reference ladder, and it reads one comparator bit back per trial. When the search ends it writes the answer to a result register and pulses a done flag.

Each conversion has three phases: a sampling phase, one trial per result bit, and one completion cycle. The length of the sampling phase is chosen so that the whole conversion takes exactly 49 or 59 cycles without sample-and-hold, and 28 or 33 cycles with it, for 8-bit and 10-bit resolution respectively. In one-shot mode the start bit drops when the result is written. In repeat mode the block converts the same channel again and again until software stops it. Repeat mode always converts at 8-bit resolution. A reference-connect output follows the power setting, and no conversion can be armed while the reference is switched off.

Top module: `sar_seq`

## Requirements
- R1: `mux_sel` holds the channel (0 to 11) that `chan_sel` carried on the clock edge that launched the conversion. It does not change while the conversion runs, even if `chan_sel` changes.
- R2: Trials are made MSB first on the 10-bit `dac_code`. A bit is kept when `cmp_hi` is 1, which means the input is at or above the trial code. A 10-bit result is the largest code whose trial was at or below the input.
- R3: At 8-bit resolution the trials use `dac_code[9:2]`, with bits 1:0 held at 0. The result sits in `conv_result[7:0]` and bits 9:8 are 0.
- R4: `conv_done` rises, and the new `conv_result` is visible, exactly T clock edges after the edge that launched the conversion. T is 59 for 10-bit without sample-and-hold, 49 for 8-bit without it, 33 for 10-bit with it, and 28 for 8-bit with it.
- R5: If `cmp_hi` stays 1 for every trial, the result is full scale: 0x3FF at 10-bit resolution and 0x0FF at 8-bit resolution.
- R6: In one-shot mode `conv_done` is high for a single cycle. `start_bit` reads 0 in that same cycle.
- R7: In repeat mode `start_bit` stays 1 and a new result with a done pulse arrives every T cycles. This holds for the channel, sample-and-hold setting and resolution fixed at launch. The resolution is 8-bit even if `res_10b` is 1.
- R8: A `sw_stop` pulse clears `start_bit` and drops a conversion that is sampling or trialling. No further `conv_done` follows, and `conv_result` keeps its last value.
- R9: With `hw_trig_sel`=1, `sw_start` only sets `start_bit`. A `cap_req` pulse launches a conversion only while `start_bit` is 1 and the block is idle. A `cap_req` that arrives while `start_bit` is 0 has no effect.
- R10: While `ref_on` is 0, `sw_start` is ignored: `start_bit` stays 0 and no conversion runs. `ref_connect` equals `ref_on` delayed by one clock.
- R11: After reset, `conv_done`, `start_bit`, `conv_result`, `ref_connect`, `dac_code` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software write of 1 to the start bit (one-cycle pulse) |
| sw_stop | input | 1 | Software write of 0 to the start bit (one-cycle pulse) |
| cap_req | input | 1 | Timer capture request (one-cycle pulse) |
| hw_trig_sel | input | 1 | 1: launch on cap_req; 0: launch on sw_start |
| chan_sel | input | 4 | Analog channel to convert, 0 to 11 |
| res_10b | input | 1 | 1: 10-bit resolution; 0: 8-bit |
| rpt_mode | input | 1 | 1: repeat mode; 0: one-shot |
| sh_on | input | 1 | Sample-and-hold enable |
| ref_on | input | 1 | Reference power setting |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above dac_code |
| mux_sel | output | 4 | Analog multiplexer select |
| dac_code | output | 10 | Trial code to the reference ladder |
| ref_connect | output | 1 | Connects the reference to the ladder |
| start_bit | output | 1 | Start bit readback |
| conv_result | output | 10 | Conversion result register |
| conv_done | output | 1 | One-cycle pulse when a result is written |

## Verification
A result and its done pulse are due exactly T edges after the launch edge. The bench records that edge by counting clocks: a launch driven at a falling edge is sampled at the next rising edge, so the due cycle is the current count plus one plus T. The driver puts the due cycle and the value computed from the ideal comparator model into a queue. The monitor samples at falling edges, pops one entry for each done pulse it sees, and compares both the value and the cycle. Any pulse that arrives while the queue is empty is reported against the requirement under test. Checks made after a register update, such as the start bit or the reference connection, are sampled at the first falling edge after that update.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAMP  = 2'd1,
        ST_TRIAL = 2'd2,
        ST_FIN   = 2'd3
    } sar_state_e;

    typedef struct packed {
        logic wide;   // full resolution search
        logic sh;     // sample-and-hold timing
        logic rpt;    // reconvert after completion
    } conv_mode_t;

    // cycles left for sampling once trials and completion are accounted for
    function automatic int phase_len(input int total, input int nbits);
        return total - nbits - 1;
    endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int CHW       = 4,
    parameter int NB_HI     = 10,
    parameter int NB_LO     = 8,
    parameter int T_LO_DIR  = 49,
    parameter int T_HI_DIR  = 59,
    parameter int T_LO_SH   = 28,
    parameter int T_HI_SH   = 33,
    parameter int CNTW      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             cap_req,
    input  logic             hw_trig_sel,
    input  logic [CHW-1:0]   chan_sel,
    input  logic             res_10b,
    input  logic             rpt_mode,
    input  logic             sh_on,
    input  logic             ref_on,
    output sar_state_e       state,
    output conv_mode_t       mode,
    output logic [CHW-1:0]   chan,
    output logic             go
);

    localparam int S_LO_DIR = phase_len(T_LO_DIR, NB_LO);
    localparam int S_HI_DIR = phase_len(T_HI_DIR, NB_HI);
    localparam int S_LO_SH  = phase_len(T_LO_SH,  NB_LO);
    localparam int S_HI_SH  = phase_len(T_HI_SH,  NB_HI);

    sar_state_e      state_q;
    conv_mode_t      mode_q;
    conv_mode_t      mode_nxt;
    logic [CHW-1:0]  chan_q;
    logic [CNTW-1:0] cnt_q;
    logic            go_q;
    logic            launch;

    function automatic logic [CNTW-1:0] samp_cnt(input conv_mode_t m);
        int n;
        if (m.sh) n = m.wide ? S_HI_SH : S_LO_SH;
        else      n = m.wide ? S_HI_DIR : S_LO_DIR;
        return CNTW'(n - 1);
    endfunction

    function automatic logic [CNTW-1:0] trial_cnt(input conv_mode_t m);
        return CNTW'((m.wide ? NB_HI : NB_LO) - 1);
    endfunction

    always_comb begin
        mode_nxt.wide = res_10b & ~rpt_mode;
        mode_nxt.sh   = sh_on;
        mode_nxt.rpt  = rpt_mode;
        launch = (state_q == ST_IDLE) && ref_on && !sw_stop &&
                 (hw_trig_sel ? (cap_req && go_q) : sw_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            chan_q  <= '0;
            cnt_q   <= '0;
            go_q    <= 1'b0;
        end else begin
            if (sw_stop)
                go_q <= 1'b0;
            else if (state_q == ST_IDLE && sw_start && ref_on)
                go_q <= 1'b1;
            else if (state_q == ST_FIN && !mode_q.rpt)
                go_q <= 1'b0;

            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q <= ST_SAMP;
                        mode_q  <= mode_nxt;
                        chan_q  <= chan_sel;
                        cnt_q   <= samp_cnt(mode_nxt);
                    end
                end
                ST_SAMP: begin
                    if (sw_stop) begin
                        state_q <= ST_IDLE;
                    end else if (cnt_q == '0) begin
                        state_q <= ST_TRIAL;
                        cnt_q   <= trial_cnt(mode_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (sw_stop) begin
                        state_q <= ST_IDLE;
                    end else if (cnt_q == '0) begin
                        state_q <= ST_FIN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_FIN: begin
                    if (mode_q.rpt && !sw_stop) begin
                        state_q <= ST_SAMP;
                        cnt_q   <= samp_cnt(mode_q);
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state = state_q;
    assign mode  = mode_q;
    assign chan  = chan_q;
    assign go    = go_q;

    a_r1_chan_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRIAL || state_q == ST_FIN) |-> $stable(chan_q));

    a_r6_busy_armed: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> go_q);

    a_r7_rpt_narrow: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && mode_q.rpt) |-> !mode_q.wide);

    a_r8_stop_halts: assert property (@(posedge clk) disable iff (rst)
        (sw_stop && state_q != ST_FIN) |=> (!go_q && state_q == ST_IDLE));

    a_r10_ref_gate: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !go_q && !ref_on) |=> (state_q == ST_IDLE && !go_q));

endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int NB_HI = 10,
    parameter int NB_LO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_state_e       state,
    input  logic             wide,
    input  logic             cmp_hi,
    output logic [NB_HI-1:0] dac_code,
    output logic [NB_HI-1:0] result,
    output logic             done
);

    localparam int SHIFT = NB_HI - NB_LO;

    logic [NB_HI-1:0] acc_q;
    logic [NB_HI-1:0] mask_q;
    logic [NB_HI-1:0] aligned;

    always_comb begin
        dac_code = (state == ST_TRIAL) ? (acc_q | mask_q) : acc_q;
        aligned  = wide ? acc_q : (acc_q >> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mask_q <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_SAMP: begin
                    acc_q  <= '0;
                    mask_q <= {1'b1, {(NB_HI-1){1'b0}}};
                end
                ST_TRIAL: begin
                    if (cmp_hi) acc_q <= acc_q | mask_q;
                    mask_q <= mask_q >> 1;
                end
                ST_FIN: begin
                    result <= aligned;
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r2_mask_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN && !wide) |=> (result[NB_HI-1:NB_LO] == '0));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int NCH      = 12,
    parameter int NB_HI    = 10,
    parameter int NB_LO    = 8,
    parameter int T_LO_DIR = 49,
    parameter int T_HI_DIR = 59,
    parameter int T_LO_SH  = 28,
    parameter int T_HI_SH  = 33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sw_start,
    input  logic                     sw_stop,
    input  logic                     cap_req,
    input  logic                     hw_trig_sel,
    input  logic [$clog2(NCH)-1:0]   chan_sel,
    input  logic                     res_10b,
    input  logic                     rpt_mode,
    input  logic                     sh_on,
    input  logic                     ref_on,
    input  logic                     cmp_hi,
    output logic [$clog2(NCH)-1:0]   mux_sel,
    output logic [NB_HI-1:0]         dac_code,
    output logic                     ref_connect,
    output logic                     start_bit,
    output logic [NB_HI-1:0]         conv_result,
    output logic                     conv_done
);

    localparam int CHW   = $clog2(NCH);
    localparam int T_MAX = (T_HI_DIR > T_LO_DIR) ? T_HI_DIR : T_LO_DIR;
    localparam int CNTW  = $clog2(T_MAX + 1);

    sar_state_e st;
    conv_mode_t md;

    sar_ctrl #(
        .CHW(CHW), .NB_HI(NB_HI), .NB_LO(NB_LO),
        .T_LO_DIR(T_LO_DIR), .T_HI_DIR(T_HI_DIR),
        .T_LO_SH(T_LO_SH), .T_HI_SH(T_HI_SH), .CNTW(CNTW)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .sw_start(sw_start), .sw_stop(sw_stop), .cap_req(cap_req),
        .hw_trig_sel(hw_trig_sel), .chan_sel(chan_sel),
        .res_10b(res_10b), .rpt_mode(rpt_mode), .sh_on(sh_on), .ref_on(ref_on),
        .state(st), .mode(md), .chan(mux_sel), .go(start_bit)
    );

    sar_approx #(.NB_HI(NB_HI), .NB_LO(NB_LO)) u_approx (
        .clk(clk), .rst(rst),
        .state(st), .wide(md.wide), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .result(conv_result), .done(conv_done)
    );

    always_ff @(posedge clk) begin
        if (rst) ref_connect <= 1'b0;
        else     ref_connect <= ref_on;
    end

    a_r10_ref_follow: assert property (@(posedge clk) disable iff (rst)
        ref_on |=> ref_connect);

endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       sw_start, sw_stop, cap_req, hw_trig_sel;
    logic [3:0] chan_sel;
    logic       res_10b, rpt_mode, sh_on, ref_on, cmp_hi;
    logic [3:0] mux_sel;
    logic [9:0] dac_code, conv_result;
    logic       ref_connect, start_bit, conv_done;

    always #5 clk = ~clk;

    sar_seq uut (
        .clk(clk), .rst(rst), .sw_start(sw_start), .sw_stop(sw_stop),
        .cap_req(cap_req), .hw_trig_sel(hw_trig_sel), .chan_sel(chan_sel),
        .res_10b(res_10b), .rpt_mode(rpt_mode), .sh_on(sh_on), .ref_on(ref_on),
        .cmp_hi(cmp_hi), .mux_sel(mux_sel), .dac_code(dac_code),
        .ref_connect(ref_connect), .start_bit(start_bit),
        .conv_result(conv_result), .conv_done(conv_done)
    );

    // ideal analog side
    logic [9:0] vin [12];
    assign cmp_hi = (mux_sel < 4'd12) ? (vin[mux_sel] >= dac_code) : 1'b0;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0;
    int fails  = 0;
    string quiet_req = "R11";
    logic prev_done = 1'b0;
    logic finished = 1'b0;

    typedef struct {
        logic [9:0] val;
        int         due;
        logic       go_exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [9:0] v, input int due, input logic g, input string tag);
        exp_t e;
        e.val = v; e.due = due; e.go_exp = g; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic sw_go(input int t, input logic [9:0] v, input string tag);
        sw_start = 1'b1;
        push(v, cyc + 1 + t, 1'b0, tag);
        tick(1);
        sw_start = 1'b0;
    endtask

    task automatic wait_empty();
        while (sb.size() != 0) tick(1);
        tick(2);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && conv_done) begin
            check(!prev_done, "R6", 1, 0);
            if (sb.size() == 0) begin
                check(1'b0, quiet_req, 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(conv_result == e.val, e.tag, conv_result, e.val);
                check(cyc == e.due, "R4", cyc, e.due);
                check(start_bit == e.go_exp, e.go_exp ? "R7" : "R6", start_bit, e.go_exp);
            end
        end
        prev_done = conv_done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        for (int i = 0; i < 12; i++) vin[i] = 10'd0;
        rst = 1'b1; sw_start = 0; sw_stop = 0; cap_req = 0; hw_trig_sel = 0;
        chan_sel = 0; res_10b = 0; rpt_mode = 0; sh_on = 0; ref_on = 0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R11 reset state
        check(conv_done == 0, "R11", conv_done, 0);
        check(start_bit == 0, "R11", start_bit, 0);
        check(conv_result == 0, "R11", conv_result, 0);
        check(ref_connect == 0, "R11", ref_connect, 0);
        check(dac_code == 0, "R11", dac_code, 0);
        check(mux_sel == 0, "R11", mux_sel, 0);

        // R10 start ignored with reference off
        quiet_req = "R10";
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        check(start_bit == 0, "R10", start_bit, 0);
        tick(80);
        check(start_bit == 0, "R10", start_bit, 0);
        ref_on = 1'b1;
        tick(1);
        check(ref_connect == 1, "R10", ref_connect, 1);

        // R2 / R1: 10-bit, no sample-and-hold, channel 3
        quiet_req = "R2";
        vin[3] = 10'h2A5; vin[7] = 10'h011;
        chan_sel = 4'd3; res_10b = 1; sh_on = 0;
        sw_go(59, 10'h2A5, "R2");
        tick(10);
        chan_sel = 4'd7;
        tick(1);
        check(mux_sel == 4'd3, "R1", mux_sel, 3);
        wait_empty();

        // R3: 8-bit, no sample-and-hold
        quiet_req = "R3";
        vin[5] = 10'h137; chan_sel = 4'd5; res_10b = 0; sh_on = 0;
        sw_go(49, 10'h04D, "R3");
        wait_empty();

        // R5: full scale both widths with sample-and-hold
        quiet_req = "R5";
        vin[11] = 10'h3FF; chan_sel = 4'd11; res_10b = 1; sh_on = 1;
        sw_go(33, 10'h3FF, "R5");
        wait_empty();
        vin[0] = 10'h3FF; chan_sel = 4'd0; res_10b = 0; sh_on = 1;
        sw_go(28, 10'h0FF, "R5");
        wait_empty();

        // R2: more patterns
        quiet_req = "R2";
        vin[8] = 10'h000; chan_sel = 4'd8; res_10b = 1; sh_on = 1;
        sw_go(33, 10'h000, "R2");
        wait_empty();
        vin[2] = 10'h001; chan_sel = 4'd2; res_10b = 1; sh_on = 0;
        sw_go(59, 10'h001, "R2");
        wait_empty();
        vin[9] = 10'h200; chan_sel = 4'd9; res_10b = 1; sh_on = 1;
        sw_go(33, 10'h200, "R2");
        wait_empty();

        // R7: repeat with 10-bit requested converts at 8 bits every 28 cycles
        quiet_req = "R8";
        vin[6] = 10'h2F3; chan_sel = 4'd6; res_10b = 1; sh_on = 1; rpt_mode = 1;
        sw_start = 1'b1;
        c0 = cyc + 1;
        push(10'h0BC, c0 + 28, 1'b1, "R7");
        push(10'h0BC, c0 + 56, 1'b1, "R7");
        push(10'h0BC, c0 + 84, 1'b1, "R7");
        tick(1);
        sw_start = 1'b0;
        while (cyc < c0 + 84) tick(1);
        vin[6] = 10'h051;
        push(10'h014, c0 + 112, 1'b1, "R7");
        while (cyc < c0 + 115) tick(1);
        check(start_bit == 1, "R7", start_bit, 1);

        // R8: stop during sampling
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        check(start_bit == 0, "R8", start_bit, 0);
        rpt_mode = 0;
        tick(100);
        check(conv_result == 10'h014, "R8", conv_result, 10'h014);
        check(sb.size() == 0, "R7", sb.size(), 0);

        // R9: hardware trigger
        quiet_req = "R9";
        hw_trig_sel = 1; vin[4] = 10'h155; chan_sel = 4'd4; res_10b = 1; sh_on = 0;
        cap_req = 1'b1; tick(1); cap_req = 1'b0;
        tick(70);
        check(start_bit == 0, "R9", start_bit, 0);
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        check(start_bit == 1, "R9", start_bit, 1);
        tick(70);
        cap_req = 1'b1;
        push(10'h155, cyc + 1 + 59, 1'b0, "R9");
        tick(1);
        cap_req = 1'b0;
        wait_empty();
        cap_req = 1'b1; tick(1); cap_req = 1'b0;
        tick(70);
        check(conv_result == 10'h155, "R9", conv_result, 10'h155);

        check(sb.size() == 0, "R4", sb.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule